// File: doc/BRIEF.md
# Banked Display Memory Controller

This block sits between a small processor's data-memory bus and two storages that share the same addresses: the general-purpose RAM (bank 0, kept outside this block) and a display RAM (bank 1) holding the segment pattern of a directly driven LCD. A one-bit bank pointer, reachable as a special register at a fixed address, decides which bank an ordinary data access reaches. Bank 1 only answers inside the window 40H to 60H (33 bytes). Outside that window it drops writes and reads as zero.

A second, independent read port on the display RAM is walked by a scanner, one location per cycle, while the oscillator enable is set. What the processor writes is therefore on the segment lines within one scan pass, with no further action. A control register holds the display enable, the oscillator enable and one select bit per shared pin. Each select bit hands its pin either to its segment line or to a port data bit. The two special registers answer in either bank. A read returns data one cycle after the read strobe.

Top module: `lcd_bank_ctrl`

## Requirements
- R1: With the bank pointer at 0, a read or write at any address other than the two special registers is forwarded to general memory (`gp_we`/`gp_re` in the same cycle, `gp_addr`/`gp_wdata` equal to the CPU's). The read data is `gp_rdata` of the next cycle, and the display RAM is not changed.
- R2: With the bank pointer at 1, an access at 40H..60H reaches display location (address − 40H). Neither general-memory strobe rises. A read returns the stored byte one cycle after `cpu_re`.
- R3: With the bank pointer at 1, a write outside 40H..60H (other than the special registers) changes nothing and raises no strobe. A read there returns 0.
- R4: The bank pointer lives at address 04H. Only wdata bit 0 is stored, it reads back with bits 7:1 zero, and it resets to 0.
- R5: The control register lives at address 1AH and resets to 0. Its fields are:
  - bits 3:0 select the function of pins 3..0;
  - bit 4 is the display enable;
  - bit 5 is the oscillator enable;
  - bits 7:6 read 0.
- R6: While the oscillator enable is 1, the scan counter steps by one per cycle through 0..32 and wraps to 0. While it is 0, the counter holds. `scan_idx` shows the location that was read at the previous clock edge.
- R7: `scan_data` is the content of location `scan_idx` as it stood before that edge. A CPU write to the same location in the same cycle is not yet visible: the scanner gets the old byte.
- R8: `seg_out` equals `scan_data` while the display enable is 1, and is all zero while it is 0.
- R9: For each shared pin i (0..3), `pin_out[i]` is `port_bits[i]` when select bit i is 1 and `seg_out[i]` when it is 0.
- R10: Reset clears every display location, the scan counter, `scan_idx` and `scan_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 8 | Data-memory address |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_re` |
| gp_we | output | 1 | Write strobe to general memory |
| gp_re | output | 1 | Read strobe to general memory |
| gp_addr | output | 8 | Address to general memory |
| gp_wdata | output | 8 | Write data to general memory |
| gp_rdata | input | 8 | General memory read data, one cycle after `gp_re` |
| port_bits | input | 4 | Port data bits for the shared pins |
| pin_out | output | 4 | Shared pin values |
| seg_out | output | 8 | Segment lines from the scanned byte |
| scan_idx | output | 6 | Display location shown on `scan_data` |
| scan_data | output | 8 | Scanned display byte |
| disp_en | output | 1 | Display enable from the control register |
| osc_en | output | 1 | Oscillator enable from the control register |

## Verification
The assertions take for granted that `cpu_we` and `cpu_re` never rise in the same cycle. They also assume that general memory answers exactly one cycle after `gp_re`. The bench keeps to both: each step issues one write, one read or an idle cycle, and it models general memory as a synchronous RAM with that latency. Random addresses are drawn mostly around the window edges (38H..68H), with bank-pointer and control writes mixed in. Directed steps force a scanner/CPU collision on one location, both with the counter running and with it held.

// File: rtl/lcdb_pkg.sv
// Shared types for the banked display memory controller.
// Assumes nothing beyond standard SystemVerilog packages.
package lcdb_pkg;

    // Source of the read data returned one cycle after a read strobe
    typedef enum logic [1:0] {
        SRC_GP   = 2'd0,
        SRC_DISP = 2'd1,
        SRC_SFR  = 2'd2,
        SRC_ZERO = 2'd3
    } rd_src_e;

endpackage

// File: rtl/lcdb_addr_decode.sv
// Address decoder: splits one CPU access between the special registers,
// general memory (bank 0) and the display window (bank 1).
// Assumes cpu_we and cpu_re are never asserted together.
module lcdb_addr_decode
    import lcdb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned WIN_BASE  = 64,
    parameter int unsigned WIN_LAST  = 96,
    parameter int unsigned BP_ADDR   = 4,
    parameter int unsigned CTRL_ADDR = 26
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic              bank_sel,
    output logic              bp_we,
    output logic              ctrl_we,
    output logic              sfr_re,
    output logic              rd_is_bp,
    output logic              gp_we,
    output logic              gp_re,
    output logic              disp_we,
    output logic              disp_re,
    output logic [IDX_W-1:0]  disp_idx,
    output rd_src_e           rd_src
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(WIN_LAST);
    localparam logic [ADDR_W-1:0] BP_A   = ADDR_W'(BP_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic hit_bp, hit_ctrl, hit_sfr, in_win;

    // Classify the address
    always_comb begin
        hit_bp   = (cpu_addr == BP_A);
        hit_ctrl = (cpu_addr == CTRL_A);
        hit_sfr  = hit_bp | hit_ctrl;
        in_win   = (cpu_addr >= BASE_A) && (cpu_addr <= LAST_A);
        disp_idx = IDX_W'(cpu_addr - BASE_A);
    end

    // Route strobes to the target selected by address and bank
    always_comb begin
        bp_we    = cpu_we & hit_bp;
        ctrl_we  = cpu_we & hit_ctrl;
        sfr_re   = cpu_re & hit_sfr;
        rd_is_bp = hit_bp;
        gp_we    = cpu_we & ~hit_sfr & ~bank_sel;
        gp_re    = cpu_re & ~hit_sfr & ~bank_sel;
        disp_we  = cpu_we & ~hit_sfr & bank_sel & in_win;
        disp_re  = cpu_re & ~hit_sfr & bank_sel & in_win;
    end

    // Pick the read-data source for the cycle after the strobe
    always_comb begin
        if (hit_sfr)        rd_src = SRC_SFR;
        else if (!bank_sel) rd_src = SRC_GP;
        else if (in_win)    rd_src = SRC_DISP;
        else                rd_src = SRC_ZERO;
    end

endmodule

// File: rtl/lcdb_sfr_regs.sv
// Bank pointer and display control register with their read path.
// Assumes a write and a read never target these registers in the same cycle.
module lcdb_sfr_regs #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NUM_SHARED = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bp_we,
    input  logic                  ctrl_we,
    input  logic                  sfr_re,
    input  logic                  rd_is_bp,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  bank_sel,
    output logic [NUM_SHARED-1:0] pin_sel,
    output logic                  disp_en,
    output logic                  osc_en,
    output logic [DATA_W-1:0]     sfr_rdata
);

    localparam int unsigned CTRL_W  = NUM_SHARED + 2;
    localparam int unsigned DEN_BIT = NUM_SHARED;
    localparam int unsigned OEN_BIT = NUM_SHARED + 1;

    logic              bank_q;
    logic [CTRL_W-1:0] ctrl_q;

    // Hold the bank pointer bit
    always_ff @(posedge clk) begin
        if (!rst_n)     bank_q <= 1'b0;
        else if (bp_we) bank_q <= wdata[0];
    end

    // Hold the implemented control bits
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata[CTRL_W-1:0];
    end

    // Register read data, unimplemented bits as zero
    always_ff @(posedge clk) begin
        if (!rst_n)      sfr_rdata <= '0;
        else if (sfr_re) sfr_rdata <= rd_is_bp ? DATA_W'(bank_q) : DATA_W'(ctrl_q);
    end

    // Break out the control fields
    always_comb begin
        bank_sel = bank_q;
        pin_sel  = ctrl_q[NUM_SHARED-1:0];
        disp_en  = ctrl_q[DEN_BIT];
        osc_en   = ctrl_q[OEN_BIT];
    end

    // R4: a bank pointer write stores bit 0 of the data
    assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bp_we) |-> bank_q == $past(wdata[0]));

    // R5: a control write stores the implemented bits
    assert_ctrl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ctrl_we) |-> ctrl_q == $past(wdata[CTRL_W-1:0]));

endmodule

// File: rtl/lcdb_disp_ram.sv
// Display RAM with a CPU port (write plus registered read) and a scanner
// port that walks every location while scanning is enabled. Both reads
// see the contents before a write made at the same edge.
// Assumes idx is inside 0..DEPTH-1 whenever we or re is set.
module lcdb_disp_ram #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 33,
    parameter int unsigned IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              scan_run,
    output logic [IDX_W-1:0]  scan_idx,
    output logic [DATA_W-1:0] scan_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  cnt;

    // Store CPU writes; reset clears the whole array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    // CPU read port, one cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[idx];
    end

    // Scanner: read the current location and advance when running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            scan_idx  <= '0;
            scan_data <= '0;
        end else begin
            scan_data <= mem[cnt];
            scan_idx  <= cnt;
            if (scan_run) cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
        end
    end

    // R6: running scanner steps by one and wraps after the last location
    assert_scan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(scan_run) |->
        cnt == (($past(cnt) == LAST_IDX) ? '0 : $past(cnt) + 1'b1));

    // R6: stopped scanner holds its position
    assert_scan_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(scan_run) |-> $stable(cnt));

endmodule

// File: rtl/lcdb_seg_mux.sv
// Segment gating and per-pin choice between segment line and port bit.
// Assumes DATA_W >= NUM_SHARED.
module lcdb_seg_mux #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NUM_SHARED = 4
) (
    input  logic                  disp_en,
    input  logic [NUM_SHARED-1:0] pin_sel,
    input  logic [NUM_SHARED-1:0] port_bits,
    input  logic [DATA_W-1:0]     scan_data,
    output logic [DATA_W-1:0]     seg_out,
    output logic [NUM_SHARED-1:0] pin_out
);

    // Blank all segments while the display is off
    always_comb seg_out = disp_en ? scan_data : '0;

    for (genvar i = 0; i < NUM_SHARED; i++) begin : g_pin
        // Hand pin i to its port bit or its segment line
        always_comb pin_out[i] = pin_sel[i] ? port_bits[i] : seg_out[i];
    end

endmodule

// File: rtl/lcd_bank_ctrl.sv
// Banked display memory controller, top level. Places a display RAM window
// in bank 1 over general-memory addresses, holds the bank pointer and the
// display control register, scans the display RAM and muxes shared pins.
// Assumes cpu_we and cpu_re are exclusive and that general memory returns
// read data one cycle after gp_re.
module lcd_bank_ctrl
    import lcdb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned WIN_BASE   = 64,
    parameter int unsigned WIN_LAST   = 96,
    parameter int unsigned BP_ADDR    = 4,
    parameter int unsigned CTRL_ADDR  = 26,
    parameter int unsigned NUM_SHARED = 4,
    localparam int unsigned DEPTH     = WIN_LAST - WIN_BASE + 1,
    localparam int unsigned IDX_W     = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  cpu_we,
    input  logic                  cpu_re,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  gp_we,
    output logic                  gp_re,
    output logic [ADDR_W-1:0]     gp_addr,
    output logic [DATA_W-1:0]     gp_wdata,
    input  logic [DATA_W-1:0]     gp_rdata,
    input  logic [NUM_SHARED-1:0] port_bits,
    output logic [NUM_SHARED-1:0] pin_out,
    output logic [DATA_W-1:0]     seg_out,
    output logic [IDX_W-1:0]      scan_idx,
    output logic [DATA_W-1:0]     scan_data,
    output logic                  disp_en,
    output logic                  osc_en
);

    logic              bank_sel, bp_we, ctrl_we, sfr_re, rd_is_bp;
    logic              disp_we, disp_re;
    logic [IDX_W-1:0]  disp_idx;
    logic [DATA_W-1:0] disp_rdata, sfr_rdata;
    logic [NUM_SHARED-1:0] pin_sel;
    rd_src_e           rd_src, src_q;

    lcdb_addr_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE),
        .WIN_LAST(WIN_LAST), .BP_ADDR(BP_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .bank_sel(bank_sel), .bp_we(bp_we), .ctrl_we(ctrl_we),
        .sfr_re(sfr_re), .rd_is_bp(rd_is_bp), .gp_we(gp_we), .gp_re(gp_re),
        .disp_we(disp_we), .disp_re(disp_re), .disp_idx(disp_idx),
        .rd_src(rd_src)
    );

    lcdb_sfr_regs #(.DATA_W(DATA_W), .NUM_SHARED(NUM_SHARED)) u_regs (
        .clk(clk), .rst_n(rst_n), .bp_we(bp_we), .ctrl_we(ctrl_we),
        .sfr_re(sfr_re), .rd_is_bp(rd_is_bp), .wdata(cpu_wdata),
        .bank_sel(bank_sel), .pin_sel(pin_sel), .disp_en(disp_en),
        .osc_en(osc_en), .sfr_rdata(sfr_rdata)
    );

    lcdb_disp_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(disp_we), .re(disp_re),
        .idx(disp_idx), .wdata(cpu_wdata), .rdata(disp_rdata),
        .scan_run(osc_en), .scan_idx(scan_idx), .scan_data(scan_data)
    );

    lcdb_seg_mux #(.DATA_W(DATA_W), .NUM_SHARED(NUM_SHARED)) u_mux (
        .disp_en(disp_en), .pin_sel(pin_sel), .port_bits(port_bits),
        .scan_data(scan_data), .seg_out(seg_out), .pin_out(pin_out)
    );

    // General memory sees the CPU address and data unchanged
    always_comb begin
        gp_addr  = cpu_addr;
        gp_wdata = cpu_wdata;
    end

    // Remember where the pending read data comes from
    always_ff @(posedge clk) begin
        if (!rst_n)      src_q <= SRC_ZERO;
        else if (cpu_re) src_q <= rd_src;
    end

    // Return the data of the selected source
    always_comb begin
        unique case (src_q)
            SRC_GP:   cpu_rdata = gp_rdata;
            SRC_DISP: cpu_rdata = disp_rdata;
            SRC_SFR:  cpu_rdata = sfr_rdata;
            default:  cpu_rdata = '0;
        endcase
    end

    // R3: a bank-1 read outside the window and off the registers returns zero
    assert_zero_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cpu_re) && $past(bank_sel) &&
        $past(cpu_addr != ADDR_W'(BP_ADDR)) && $past(cpu_addr != ADDR_W'(CTRL_ADDR)) &&
        ($past(cpu_addr < ADDR_W'(WIN_BASE)) || $past(cpu_addr > ADDR_W'(WIN_LAST)))
        |-> cpu_rdata == '0);

    // R2: bank 1 never strobes general memory
    assert_gp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel |-> !gp_we && !gp_re);

endmodule

// File: tb/sim_lcd_bank_ctrl.sv
module sim_lcd_bank_ctrl;

    localparam int BP_A   = 8'h04;
    localparam int CTRL_A = 8'h1A;
    localparam int BASE   = 8'h40;
    localparam int LAST   = 8'h60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic       cpu_we = 1'b0;
    logic       cpu_re = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       gp_we, gp_re;
    logic [7:0] gp_addr, gp_wdata;
    logic [7:0] gp_rdata = '0;
    logic [3:0] port_bits = '0;
    logic [3:0] pin_out;
    logic [7:0] seg_out;
    logic [5:0] scan_idx;
    logic [7:0] scan_data;
    logic       disp_en, osc_en;

    int checks = 0;
    int errors = 0;

    logic [7:0] gmem [256];
    logic       m_bp = 1'b0;
    logic [5:0] m_ctrl = '0;
    logic [7:0] m_disp [33];
    logic [7:0] m_gp [256];
    int         m_cnt = 0;

    always #10 clk = ~clk;

    lcd_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_re(cpu_re), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .gp_we(gp_we), .gp_re(gp_re), .gp_addr(gp_addr), .gp_wdata(gp_wdata),
        .gp_rdata(gp_rdata), .port_bits(port_bits), .pin_out(pin_out),
        .seg_out(seg_out), .scan_idx(scan_idx), .scan_data(scan_data),
        .disp_en(disp_en), .osc_en(osc_en)
    );

    // Behavioural general memory, one cycle read latency
    always @(posedge clk) begin
        if (gp_we) gmem[gp_addr] <= gp_wdata;
        if (gp_re) gp_rdata <= gmem[gp_addr];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic logic [7:0] exp_read(input int a);
        if (a == BP_A)   return {7'b0, m_bp};
        if (a == CTRL_A) return {2'b0, m_ctrl};
        if (!m_bp)       return m_gp[a];
        if (a >= BASE && a <= LAST) return m_disp[a - BASE];
        return 8'h00;
    endfunction

    function automatic string read_tag(input int a);
        if (a == BP_A)   return "R4";
        if (a == CTRL_A) return "R5";
        if (!m_bp)       return "R1";
        if (a >= BASE && a <= LAST) return "R2";
        return "R3";
    endfunction

    // One bus cycle: drive at a falling edge, check at the next one
    task automatic step(input bit we, input bit re, input int a, input logic [7:0] d);
        logic [7:0] exp_rd, exp_sd, exp_seg;
        int         exp_idx;
        bit         sfr, old_osc, exp_gw, exp_gr;
        string      tag;
        cpu_we = we; cpu_re = re; cpu_addr = 8'(a); cpu_wdata = d;
        port_bits = 4'($urandom);
        #1;
        sfr    = (a == BP_A) || (a == CTRL_A);
        exp_gw = we && !sfr && !m_bp;
        exp_gr = re && !sfr && !m_bp;
        tag    = m_bp ? "R2/R3 strobe" : "R1 strobe";
        check(gp_we == exp_gw && gp_re == exp_gr, tag, {gp_we, gp_re}, {exp_gw, exp_gr});
        if (exp_gw || exp_gr)
            check(gp_addr == 8'(a) && gp_wdata == d, "R1 addr/data", gp_addr, a);
        exp_rd  = exp_read(a);
        tag     = read_tag(a);
        exp_idx = m_cnt;
        exp_sd  = m_disp[m_cnt];
        old_osc = m_ctrl[5];
        if (we) begin
            if (a == BP_A)                   m_bp = d[0];
            else if (a == CTRL_A)            m_ctrl = d[5:0];
            else if (!m_bp)                  m_gp[a] = d;
            else if (a >= BASE && a <= LAST) m_disp[a - BASE] = d;
        end
        if (old_osc) m_cnt = (m_cnt == 32) ? 0 : m_cnt + 1;
        @(negedge clk);
        if (re) check(cpu_rdata == exp_rd, tag, cpu_rdata, exp_rd);
        check(int'(scan_idx) == exp_idx, "R6 scan_idx", scan_idx, exp_idx);
        check(scan_data == exp_sd, "R7 scan_data", scan_data, exp_sd);
        exp_seg = m_ctrl[4] ? exp_sd : 8'h00;
        check(seg_out == exp_seg, "R8 seg_out", seg_out, exp_seg);
        check(disp_en == m_ctrl[4] && osc_en == m_ctrl[5], "R5 enables",
              {disp_en, osc_en}, {m_ctrl[4], m_ctrl[5]});
        for (int i = 0; i < 4; i++) begin
            logic e;
            e = m_ctrl[i] ? port_bits[i] : exp_seg[i];
            check(pin_out[i] == e, "R9 pin_out", pin_out[i], e);
        end
        cpu_we = 1'b0; cpu_re = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin gmem[i] = '0; m_gp[i] = '0; end
        for (int i = 0; i < 33; i++) m_disp[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 / R5: reset state
        check(scan_idx == 6'd0 && scan_data == 8'h00, "R10 reset scan", scan_data, 0);
        check(seg_out == 8'h00 && pin_out == 4'h0, "R10 reset outputs", seg_out, 0);
        check(disp_en == 1'b0 && osc_en == 1'b0, "R5 reset enables", {disp_en, osc_en}, 0);
        step(0, 1, BP_A, 8'h00);     // R4 reset value
        step(0, 1, CTRL_A, 8'h00);   // R5 reset value
        step(0, 1, 8'h45, 8'h00);    // R1 bank 0 read
        // R4: only bit 0 stored
        step(1, 0, BP_A, 8'hFF);
        step(0, 1, BP_A, 8'h00);
        // R10: display cleared by reset, read in bank 1
        step(0, 1, 8'h50, 8'h00);
        // R2: window edges
        step(1, 0, 8'h40, 8'hA5);
        step(1, 0, 8'h60, 8'h3C);
        step(0, 1, 8'h40, 8'h00);
        step(0, 1, 8'h60, 8'h00);
        // R3: just outside the window
        step(1, 0, 8'h3F, 8'h77);
        step(1, 0, 8'h61, 8'h88);
        step(0, 1, 8'h3F, 8'h00);
        step(0, 1, 8'h61, 8'h00);
        // R3: bank 0 at the same address was not touched
        step(1, 0, BP_A, 8'h00);
        step(0, 1, 8'h3F, 8'h00);
        step(1, 0, 8'h42, 8'h5A);    // R1 bank 0 write under the window
        step(0, 1, 8'h42, 8'h00);
        step(1, 0, BP_A, 8'h01);
        step(0, 1, 8'h42, 8'h00);    // R2 display side unchanged
        // R5: unimplemented bits read 0, scanner runs, display on
        step(1, 0, CTRL_A, 8'hF5);
        step(0, 1, CTRL_A, 8'h00);
        for (int k = 0; k < 40; k++) step(0, 0, 0, 8'h00);   // R6 wrap
        // R7: collision while running
        step(1, 0, BASE + m_cnt, 8'hC3);
        step(1, 0, BASE + m_cnt, 8'h1E);
        // R7: collision with scanner held, then new data appears
        step(1, 0, CTRL_A, 8'h10);
        step(1, 0, BASE + m_cnt, 8'h99);
        step(0, 0, 0, 8'h00);
        step(0, 0, 0, 8'h00);
        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            int r, a;
            r = $urandom_range(0, 99);
            a = (r < 80) ? $urandom_range(8'h38, 8'h68) : $urandom_range(0, 255);
            if (r < 8)       step(1, 0, BP_A, 8'($urandom));
            else if (r < 14) step(1, 0, CTRL_A, 8'($urandom));
            else if (r < 50) step(1, 0, a, 8'($urandom));
            else if (r < 90) step(0, 1, a, 8'h00);
            else             step(0, 0, a, 8'h00);
        end
        summary();
        $finish;
    end

endmodule